// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block sits beside a processor core and gathers up to 32 interrupt request lines into an interrupt-set register. The register is masked by an enable vector. Each interrupt is assigned to a numbered priority level through a per-level bit mask. The block searches the levels from the highest one down. It reports the first level that lies above the core's current interrupt level and has at least one pending, enabled member. It also raises a hard-interrupt request to the core.

Each line is configured as either level-type or edge-type. A level-type bit follows its line. An edge-type bit stays latched after its line falls, until a synchronous clear from software removes it. Compare-timer match pulses are routed onto chosen interrupt indexes and act like asserted request lines. Indexes at or above the configured interrupt count are ignored everywhere.

The request output is held in a two-state register. ST_QUIET means no request is raised. ST_RAISED means a request is raised. Two transitions connect them. The search_hit transition goes from ST_QUIET to ST_RAISED when the search finds a level. The search_miss transition goes from ST_RAISED to ST_QUIET when it finds none. A state that sees a hit stays in ST_RAISED, and a state that sees a miss stays in ST_QUIET. The pending-level register is loaded at the same edge as the state register.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: While reset is asserted, and at the first edge after it with no requests, the set register is empty, pend_level is 0 and irq_hard is 0.
- R2: Only bits that are both set and enabled (irq_enable bit = 1) take part in the search; a set but disabled interrupt produces no request.
- R3: Levels are searched from NUM_LEVELS down to 1. The chosen level is the first one that is greater than cur_level and whose mask (level L at level_masks bits [(L-1)*32 +: 32]) shares a bit with the enabled set bits. pend_level shows that level number and irq_hard is 1.
- R4: When no level qualifies, pend_level is 0 and irq_hard is 0. irq_hard is 1 exactly when pend_level is non-zero.
- R5: A request line that is high sets its bit in the set register.
- R6: With edge_type bit = 0 (level-type), a low line clears its bit. With edge_type bit = 1 (edge-type), the bit stays set after the line falls.
- R7: Request lines, timer mappings and edge bits at indexes at or above NUM_CFG (default 24) have no effect on the outputs.
- R8: Timer t is mapped to the index held in tmr_map bits [t*5 +: 5]. A pulse on tmr_match[t] sets that interrupt as if its line were high.
- R9: When clr_en is high, the edge-type bits selected by clr_mask are cleared. A line or timer that is high in the same cycle keeps its bit set.
- R10: pend_level and irq_hard change at the first rising clock edge that samples a changed input, and not before that edge.
- R11: A cur_level of NUM_LEVELS or more suppresses every request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines | input | 32 | Raw interrupt request lines |
| irq_enable | input | 32 | Per-interrupt enable |
| edge_type | input | 32 | 1 = edge-type (latched), 0 = level-type |
| level_masks | input | 32*NUM_LEVELS | Member mask of each level, level L at bits [(L-1)*32 +: 32] |
| cur_level | input | 4 | Current interrupt level of the core |
| tmr_match | input | NUM_TMR | Compare-timer match pulses |
| tmr_map | input | 5*NUM_TMR | Interrupt index for each timer |
| clr_en | input | 1 | Software clear strobe for edge-type bits |
| clr_mask | input | 32 | Bits to clear when clr_en is high |
| pend_level | output | 4 | Selected pending level, 0 when none |
| irq_hard | output | 1 | Hard-interrupt request to the core |

## Verification
The set register is not visible at the ports, so a bit that is wrongly kept or wrongly dropped shows up only through the level search. The bench exposes each such bit by enabling it and placing it alone in a known level. The outputs then show whether a latched edge bit survived, whether a level bit fell, and whether a clear or a timer pulse took effect. Each error appears at the first edge after the stimulus. A wrong search order or a wrong threshold compare shows as a wrong pend_level number at that edge. A mismatch between the state register and the level register shows as irq_hard disagreeing with pend_level being non-zero.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
    localparam int LVL_W = 4;
    typedef logic [LVL_W-1:0] lvl_t;

    // Request output state: quiet or raised toward the core
    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } req_state_e;
endpackage

// File: rtl/lvl_irq_tmap.sv
// Routes compare-timer match pulses onto their configured interrupt lines.
module lvl_irq_tmap #(
    parameter int NUM_IRQ = 32,
    parameter int NUM_CFG = 24,
    parameter int NUM_TMR = 3,
    parameter int IDX_W   = $clog2(NUM_IRQ)
) (
    input  logic [NUM_TMR-1:0]       tmr_match,
    input  logic [NUM_TMR*IDX_W-1:0] tmr_map,
    output logic [NUM_IRQ-1:0]       tmr_lines
);
    logic [NUM_IRQ-1:0] hit_per_tmr [NUM_TMR];

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        always_comb begin
            hit_per_tmr[t] = '0;
            for (int i = 0; i < NUM_CFG; i++) begin
                if (tmr_match[t] && (tmr_map[t*IDX_W +: IDX_W] == IDX_W'(i)))
                    hit_per_tmr[t][i] = 1'b1;
            end
        end
    end

    always_comb begin
        tmr_lines = '0;
        for (int t = 0; t < NUM_TMR; t++)
            tmr_lines = tmr_lines | hit_per_tmr[t];
    end
endmodule

// File: rtl/lvl_irq_latch.sv
// Interrupt-set register: level-type bits follow the line, edge-type bits hold.
module lvl_irq_latch #(
    parameter int NUM_IRQ = 32,
    parameter int NUM_CFG = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] req_on,
    input  logic [NUM_IRQ-1:0] edge_type,
    input  logic               clr_en,
    input  logic [NUM_IRQ-1:0] clr_mask,
    output logic [NUM_IRQ-1:0] set_next
);
    localparam logic [NUM_IRQ-1:0] CFG_MASK =
        (NUM_CFG >= NUM_IRQ) ? {NUM_IRQ{1'b1}} : NUM_IRQ'((64'd1 << NUM_CFG) - 64'd1);

    logic [NUM_IRQ-1:0] set_q;
    logic [NUM_IRQ-1:0] clr_vec;
    logic [NUM_IRQ-1:0] held;

    always_comb begin
        clr_vec  = clr_en ? clr_mask : '0;
        held     = set_q & edge_type & ~clr_vec;
        set_next = (req_on | held) & CFG_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) set_q <= '0;
        else        set_q <= set_next;
    end
endmodule

// File: rtl/lvl_irq_select.sv
// Finds the highest level above the threshold with an enabled pending member.
module lvl_irq_select
    import lvl_irq_pkg::*;
#(
    parameter int NUM_IRQ    = 32,
    parameter int NUM_LEVELS = 6
) (
    input  logic [NUM_IRQ-1:0]            eff_pend,
    input  logic [NUM_LEVELS*NUM_IRQ-1:0] level_masks,
    input  lvl_t                          cur_level,
    output logic                          found,
    output lvl_t                          found_level
);
    logic [NUM_LEVELS:1] lvl_hit;

    for (genvar l = 1; l <= NUM_LEVELS; l++) begin : g_lvl
        assign lvl_hit[l] = (lvl_t'(l) > cur_level) &&
                            (|(level_masks[(l-1)*NUM_IRQ +: NUM_IRQ] & eff_pend));
    end

    always_comb begin
        found       = 1'b0;
        found_level = '0;
        for (int l = NUM_LEVELS; l >= 1; l--) begin
            if (!found && lvl_hit[l]) begin
                found       = 1'b1;
                found_level = lvl_t'(l);
            end
        end
    end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
    import lvl_irq_pkg::*;
#(
    parameter int NUM_IRQ    = 32,
    parameter int NUM_CFG    = 24,
    parameter int NUM_LEVELS = 6,
    parameter int NUM_TMR    = 3,
    localparam int IDX_W     = $clog2(NUM_IRQ)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_IRQ-1:0]            irq_lines,
    input  logic [NUM_IRQ-1:0]            irq_enable,
    input  logic [NUM_IRQ-1:0]            edge_type,
    input  logic [NUM_LEVELS*NUM_IRQ-1:0] level_masks,
    input  logic [LVL_W-1:0]              cur_level,
    input  logic [NUM_TMR-1:0]            tmr_match,
    input  logic [NUM_TMR*IDX_W-1:0]      tmr_map,
    input  logic                          clr_en,
    input  logic [NUM_IRQ-1:0]            clr_mask,
    output logic [LVL_W-1:0]              pend_level,
    output logic                          irq_hard
);
    logic [NUM_IRQ-1:0] tmr_lines;
    logic [NUM_IRQ-1:0] set_next;
    logic [NUM_IRQ-1:0] eff_pend;
    logic               found;
    lvl_t               found_level;
    req_state_e         state_q, state_d;
    lvl_t               level_q;

    lvl_irq_tmap #(
        .NUM_IRQ(NUM_IRQ), .NUM_CFG(NUM_CFG), .NUM_TMR(NUM_TMR), .IDX_W(IDX_W)
    ) u_tmap (
        .tmr_match(tmr_match),
        .tmr_map  (tmr_map),
        .tmr_lines(tmr_lines)
    );

    lvl_irq_latch #(.NUM_IRQ(NUM_IRQ), .NUM_CFG(NUM_CFG)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_on   (irq_lines | tmr_lines),
        .edge_type(edge_type),
        .clr_en   (clr_en),
        .clr_mask (clr_mask),
        .set_next (set_next)
    );

    // Search works on the value being loaded so outputs trail inputs by one edge
    assign eff_pend = set_next & irq_enable;

    lvl_irq_select #(.NUM_IRQ(NUM_IRQ), .NUM_LEVELS(NUM_LEVELS)) u_sel (
        .eff_pend   (eff_pend),
        .level_masks(level_masks),
        .cur_level  (cur_level),
        .found      (found),
        .found_level(found_level)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:  if (found)  state_d = ST_RAISED;  // search_hit
            ST_RAISED: if (!found) state_d = ST_QUIET;   // search_miss
            default:               state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     level_q <= '0;
        else if (found) level_q <= found_level;
        else            level_q <= '0;
    end

    assign pend_level = level_q;
    assign irq_hard   = (state_q == ST_RAISED);
endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
module lvl_irq_ctrl_chk #(
    parameter int NUM_IRQ    = 32,
    parameter int NUM_LEVELS = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_IRQ-1:0] irq_enable,
    input logic [3:0]         cur_level,
    input logic [3:0]         pend_level,
    input logic               irq_hard
);
    // R4: request and level register agree
    p_hard_matches_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hard == (pend_level != 4'd0));

    // R3: reported level never exceeds the configured count
    p_level_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pend_level <= 4'(NUM_LEVELS));

    // R3: a raised request lies above the threshold seen at its edge
    p_above_current_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hard |-> (pend_level > $past(cur_level)));

    // R2: nothing enabled means nothing raised
    p_disabled_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_enable) == '0) |-> !irq_hard);

    // R11: a threshold at or above the top level suppresses everything
    p_threshold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cur_level) >= 4'(NUM_LEVELS)) |-> !irq_hard);
endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk #(.NUM_IRQ(NUM_IRQ), .NUM_LEVELS(NUM_LEVELS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_enable(irq_enable),
    .cur_level (cur_level),
    .pend_level(pend_level),
    .irq_hard  (irq_hard)
);

// File: tb/lvl_irq_ctrl_bench.sv
module lvl_irq_ctrl_bench;
    localparam int NI = 32;
    localparam int NL = 6;
    localparam int NT = 3;
    localparam int NV = 14;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NI-1:0]   irq_lines = '0;
    logic [NI-1:0]   irq_enable = '0;
    logic [NI-1:0]   edge_type = '0;
    logic [NL*NI-1:0] level_masks;
    logic [3:0]      cur_level = '0;
    logic [NT-1:0]   tmr_match = '0;
    logic [NT*5-1:0] tmr_map = '0;
    logic            clr_en = 1'b0;
    logic [NI-1:0]   clr_mask = '0;
    logic [3:0]      pend_level;
    logic            irq_hard;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lvl_irq_ctrl u_lvl_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .irq_enable(irq_enable),
        .edge_type(edge_type), .level_masks(level_masks), .cur_level(cur_level),
        .tmr_match(tmr_match), .tmr_map(tmr_map), .clr_en(clr_en), .clr_mask(clr_mask),
        .pend_level(pend_level), .irq_hard(irq_hard)
    );

    // {lines, enable, cur_level, expected level}; all lines level-type
    localparam logic [71:0] VEC [NV] = '{
        {32'h0000_0001, 32'hFFFF_FFFF, 4'd0, 4'd1},  // R3 R5 single level 1
        {32'h0010_0011, 32'hFFFF_FFFF, 4'd0, 4'd6},  // R3 highest wins
        {32'h0010_0011, 32'hFFFF_FFFF, 4'd5, 4'd6},  // R3 just above threshold
        {32'h0010_0011, 32'hFFFF_FFFF, 4'd6, 4'd0},  // R11 top threshold
        {32'h0000_0011, 32'h0000_0010, 4'd0, 4'd2},  // R2 enable picks bit 4
        {32'h0000_0011, 32'h0000_0001, 4'd0, 4'd1},  // R2 enable picks bit 0
        {32'h0000_0011, 32'h0000_0000, 4'd0, 4'd0},  // R2 none enabled
        {32'h0000_0011, 32'hFFFF_FFFF, 4'd2, 4'd0},  // R4 all at or below
        {32'h0000_0011, 32'hFFFF_FFFF, 4'd1, 4'd2},  // R3 level 2 above 1
        {32'h0F00_0000, 32'hFFFF_FFFF, 4'd0, 4'd0},  // R7 out-of-range lines
        {32'h0080_0000, 32'hFFFF_FFFF, 4'd5, 4'd6},  // R3 last configured line
        {32'h0000_0100, 32'hFFFF_FFFF, 4'd0, 4'd3},  // R5 level 3
        {32'h0000_1000, 32'hFFFF_FEFF, 4'd15, 4'd0}, // R11 max threshold
        {32'h0000_0000, 32'hFFFF_FFFF, 4'd0, 4'd0}   // R6 level bits drop
    };

    task automatic chk(input string tag, input logic [3:0] exp_lvl);
        total++;
        if (pend_level !== exp_lvl || irq_hard !== (exp_lvl != 4'd0)) begin
            fails++;
            $display("FAIL %s: level=%0d hard=%0b expected level=%0d hard=%0b",
                     tag, pend_level, irq_hard, exp_lvl, exp_lvl != 4'd0);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        for (int l = 1; l <= NL; l++) begin
            level_masks[(l-1)*NI +: NI] = (l == NL) ? 32'hFFF0_0000
                                                    : (32'hF << ((l-1)*4));
        end
        #1;
        chk("R1 during reset", 4'd0);
        repeat (3) @(negedge clk);
        chk("R1 held reset", 4'd0);
        rst_n = 1'b1;
        irq_enable = '1;
        step();
        chk("R1 after reset", 4'd0);

        for (int v = 0; v < NV; v++) begin
            irq_lines  = VEC[v][71:40];
            irq_enable = VEC[v][39:8];
            cur_level  = VEC[v][7:4];
            step();
            chk($sformatf("R3/R4 vector %0d", v), VEC[v][3:0]);
        end

        // R10: no change before the edge, change right after it
        irq_enable = '1;
        cur_level  = 4'd0;
        irq_lines  = 32'h0000_0010;
        #1;
        chk("R10 before edge", 4'd0);
        step();
        chk("R10 after edge", 4'd2);
        irq_lines = '0;
        step();
        chk("R6 level bit cleared", 4'd0);

        // R6: edge-type bit 8 stays after its line falls
        edge_type = 32'h1001_0100;
        irq_lines = 32'h0000_0100;
        step();
        irq_lines = '0;
        step();
        step();
        chk("R6 edge bit held", 4'd3);

        // R9: line high wins over clear in the same cycle
        irq_lines = 32'h0000_0100;
        clr_en    = 1'b1;
        clr_mask  = 32'h0000_0100;
        step();
        chk("R9 set beats clear", 4'd3);
        irq_lines = '0;
        step();
        clr_en = 1'b0;
        step();
        chk("R9 clear removes edge bit", 4'd0);

        // R8: timer 0 mapped to index 16 (level 5), edge-type
        tmr_map   = {5'd2, 5'd28, 5'd16};
        tmr_match = 3'b001;
        step();
        tmr_match = 3'b000;
        step();
        chk("R8 timer sets mapped line", 4'd5);
        clr_en   = 1'b1;
        clr_mask = 32'h0001_0000;
        step();
        clr_en = 1'b0;
        chk("R9 timer bit cleared", 4'd0);

        // R7: timer 1 targets index 28, edge-type but unconfigured
        tmr_match = 3'b010;
        step();
        tmr_match = 3'b000;
        step();
        chk("R7 timer out of range", 4'd0);

        // R7: edge line at 28 pulses and must not latch
        irq_lines = 32'h1000_0000;
        step();
        irq_lines = '0;
        step();
        chk("R7 edge line out of range", 4'd0);

        // R8: timer 2 on level-type index 2 follows its pulse
        tmr_match = 3'b100;
        step();
        chk("R8 timer level-type on", 4'd1);
        tmr_match = 3'b000;
        step();
        chk("R8 timer level-type off", 4'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", total, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", total, fails);
            $finish;
        end
    end
endmodule